// File: doc/BRIEF.md
# 64-bit Free-Running Timer with Compare Interrupt

This block is a 64-bit up-counter with a 64-bit compare register, a sticky match flag and a level interrupt. Software reaches it over a 32-bit register bus with a write strobe, a read strobe and a byte address. The counter and the compare value each appear as two 32-bit words. A control word gates counting, comparison and interrupt delivery. A status word holds the match event until software clears it by writing a one.

The counter words are not captured together when one of them is read. Software obtains a consistent 64-bit value by reading the high word, the low word and the high word again, and repeating if the two high reads differ. Because the compare value is also written one word at a time, software turns the comparator off while it rewrites either word, so that a half-updated value cannot raise a false match.

Read data is combinational: it is valid in the same cycle as the read strobe and is zero when the strobe is low.

Top module: `gtmr_top`

## Requirements
- R1: After reset the counter, the compare value, the control word and the match flag are zero, and `irq` is low.
- R2: While control bit 0 (run) is 1 the counter increases by one on every clock edge; while it is 0 the counter holds. The edge that writes the control word still uses the previous run bit.
- R3: Byte offsets are: 0x00 counter low word, 0x04 counter high word, 0x08 control, 0x0C status, 0x10 compare low word, 0x14 compare high word. Control reads back bits 2:0 as written and zero in bits 31:3.
- R4: A write to a counter word or a compare word loads only that word; the other word of the same register is left alone (the counter's other word still counts).
- R5: The two counter words are read with no snapshot, so a carry between two reads is visible; a high/low/high read with retry returns a consistent 64-bit value across a low-word rollover.
- R6: When control bit 1 (compare enable) is 1 and the counter is greater than or equal to the compare value, the match flag (status bit 0) is 1 after that clock edge and stays 1 until cleared.
- R7: Writing status with bit 0 = 1 clears the match flag; writing it with bit 0 = 0 has no effect.
- R8: If a clearing write and a match occur at the same edge, the flag stays 1.
- R9: `irq` is a register that takes, one clock later, the match flag ANDed with control bit 2 (interrupt enable) and control bit 1 (compare enable).
- R10: Reads from any other offset return zero, and writes to any other offset change no register.
- R11: While compare enable is 0, no counter or compare value sets the match flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Byte offset of the access |
| wrData | input | HALF_W (32) | Write data |
| rdData | output | HALF_W (32) | Read data, zero when rdEn is low |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its defaults, a 32-bit word and an 8-bit byte offset, so the counter is 64 bits wide and the compare is a full 64-bit magnitude test. Because either counter word can be preloaded, a low-word rollover is reached within a few cycles, which lets the bench watch a torn high/low/high read and the retry that repairs it. Compare values are placed just above and below preloaded counts so that match, sticky hold, clear, and a clear colliding with a live match all occur at chosen edges.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

  // Byte offsets of the register words
  localparam int unsigned OffCntLo = 'h00;
  localparam int unsigned OffCntHi = 'h04;
  localparam int unsigned OffCtrl  = 'h08;
  localparam int unsigned OffStat  = 'h0C;
  localparam int unsigned OffCmpLo = 'h10;
  localparam int unsigned OffCmpHi = 'h14;

  // Control word bit positions
  localparam int unsigned CtlRun = 0;
  localparam int unsigned CtlCmp = 1;
  localparam int unsigned CtlIrq = 2;
  localparam int unsigned CtlW   = 3;

  // Status word bit position
  localparam int unsigned StsHit = 0;

  // Strobes from control to datapath
  typedef struct packed {
    logic ldCntLo;
    logic ldCntHi;
    logic ldCmpLo;
    logic ldCmpHi;
    logic cntEn;
    logic cmpEn;
  } dpStrobe_t;

endpackage

// File: rtl/gtmr_datapath.sv
module gtmr_datapath
  import gtmr_pkg::*;
#(
  parameter int unsigned HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strb,
  input  logic [HALF_W-1:0]     wrData,
  output logic [2*HALF_W-1:0]   cntQ,
  output logic [2*HALF_W-1:0]   cmpQ,
  output logic                  matchHit
);

  localparam int unsigned CntW   = 2 * HALF_W;
  localparam int unsigned NHalf  = 2;

  logic [CntW-1:0]  cntStep;
  logic [CntW-1:0]  cntNext;
  logic [CntW-1:0]  cmpNext;
  logic [NHalf-1:0] ldCnt;
  logic [NHalf-1:0] ldCmp;

  assign ldCnt   = {strb.ldCntHi, strb.ldCntLo};
  assign ldCmp   = {strb.ldCmpHi, strb.ldCmpLo};
  assign cntStep = strb.cntEn ? cntQ + CntW'(1) : cntQ;

  // Each word of counter and compare loads on its own strobe
  for (genvar h = 0; h < NHalf; h++) begin : g_half
    assign cntNext[h*HALF_W +: HALF_W] = ldCnt[h] ? wrData : cntStep[h*HALF_W +: HALF_W];
    assign cmpNext[h*HALF_W +: HALF_W] = ldCmp[h] ? wrData : cmpQ[h*HALF_W +: HALF_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      cmpQ <= '0;
    end else begin
      cntQ <= cntNext;
      cmpQ <= cmpNext;
    end
  end

  assign matchHit = strb.cmpEn && (cntQ >= cmpQ);

endmodule

// File: rtl/gtmr_ctrl.sv
module gtmr_ctrl
  import gtmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned HALF_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [HALF_W-1:0]    wrData,
  input  logic [2*HALF_W-1:0]  cntQ,
  input  logic [2*HALF_W-1:0]  cmpQ,
  input  logic                 matchHit,
  output dpStrobe_t            strb,
  output logic [HALF_W-1:0]    rdData,
  output logic                 irq,
  output logic                 flagQ,
  output logic [CtlW-1:0]      ctrlQ
);

  logic selCntLo, selCntHi, selCtrl, selStat, selCmpLo, selCmpHi;
  logic clrHit;
  logic flagNext;

  assign selCntLo = (addr == ADDR_W'(OffCntLo));
  assign selCntHi = (addr == ADDR_W'(OffCntHi));
  assign selCtrl  = (addr == ADDR_W'(OffCtrl));
  assign selStat  = (addr == ADDR_W'(OffStat));
  assign selCmpLo = (addr == ADDR_W'(OffCmpLo));
  assign selCmpHi = (addr == ADDR_W'(OffCmpHi));

  always_comb begin
    strb.ldCntLo = wrEn && selCntLo;
    strb.ldCntHi = wrEn && selCntHi;
    strb.ldCmpLo = wrEn && selCmpLo;
    strb.ldCmpHi = wrEn && selCmpHi;
    strb.cntEn   = ctrlQ[CtlRun];
    strb.cmpEn   = ctrlQ[CtlCmp];
  end

  assign clrHit   = wrEn && selStat && wrData[StsHit];
  assign flagNext = matchHit || (flagQ && !clrHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      flagQ <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (wrEn && selCtrl) ctrlQ <= wrData[CtlW-1:0];
      flagQ <= flagNext;
      irq   <= flagQ && ctrlQ[CtlIrq] && ctrlQ[CtlCmp];
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (selCntLo)      rdData = cntQ[HALF_W-1:0];
      else if (selCntHi) rdData = cntQ[2*HALF_W-1:HALF_W];
      else if (selCtrl)  rdData[CtlW-1:0] = ctrlQ;
      else if (selStat)  rdData[StsHit] = flagQ;
      else if (selCmpLo) rdData = cmpQ[HALF_W-1:0];
      else if (selCmpHi) rdData = cmpQ[2*HALF_W-1:HALF_W];
    end
  end

endmodule

// File: rtl/gtmr_top.sv
module gtmr_top
  import gtmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0] wrData,
  output logic [HALF_W-1:0] rdData,
  output logic              irq
);

  localparam int unsigned CntW = 2 * HALF_W;

  dpStrobe_t        strb;
  logic [CntW-1:0]  cntVal;
  logic [CntW-1:0]  cmpVal;
  logic             matchHit;
  logic             statusFlag;
  logic [CtlW-1:0]  ctrlBits;

  gtmr_ctrl #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .addr     (addr),
    .wrData   (wrData),
    .cntQ     (cntVal),
    .cmpQ     (cmpVal),
    .matchHit (matchHit),
    .strb     (strb),
    .rdData   (rdData),
    .irq      (irq),
    .flagQ    (statusFlag),
    .ctrlQ    (ctrlBits)
  );

  gtmr_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .cntQ     (cntVal),
    .cmpQ     (cmpVal),
    .matchHit (matchHit)
  );

endmodule

// File: rtl/gtmr_checker.sv
module gtmr_checker
  import gtmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned HALF_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic                rdEn,
  input logic [ADDR_W-1:0]   addr,
  input logic [HALF_W-1:0]   wrData,
  input logic [HALF_W-1:0]   rdData,
  input logic                irq,
  input logic [2*HALF_W-1:0] cntVal,
  input logic [2*HALF_W-1:0] cmpVal,
  input logic                statusFlag,
  input logic [CtlW-1:0]     ctrlBits
);

  logic cntWrite, clrWrite, mapped;

  assign cntWrite = wrEn && (addr == ADDR_W'(OffCntLo) || addr == ADDR_W'(OffCntHi));
  assign clrWrite = wrEn && (addr == ADDR_W'(OffStat)) && wrData[StsHit];
  assign mapped   = (addr == ADDR_W'(OffCntLo)) || (addr == ADDR_W'(OffCntHi)) ||
                    (addr == ADDR_W'(OffCtrl))  || (addr == ADDR_W'(OffStat))  ||
                    (addr == ADDR_W'(OffCmpLo)) || (addr == ADDR_W'(OffCmpHi));

  // R2: counting steps by one
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBits[CtlRun] && !cntWrite) |=> cntVal == $past(cntVal) + 1'b1);

  // R2: counter holds when stopped
  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlBits[CtlRun] && !cntWrite) |=> $stable(cntVal));

  // R3: upper control bits read zero
  a_r3_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(OffCtrl)) |-> rdData[HALF_W-1:CtlW] == '0);

  // R6 and R8: a match sets the flag, even against a clear
  a_r6_match_sets: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBits[CtlCmp] && cntVal >= cmpVal) |=> statusFlag);

  // R6: flag is sticky without a clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (statusFlag && !clrWrite) |=> statusFlag);

  // R9: interrupt only follows a pending, enabled flag
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(statusFlag) && $past(ctrlBits[CtlIrq]) && $past(ctrlBits[CtlCmp]));

  // R10: unmapped reads return zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !mapped) |-> rdData == '0);

  // R11: no set while compare is disabled
  a_r11_no_set_off: assert property (@(posedge clk) disable iff (!rstN)
    (!statusFlag && !ctrlBits[CtlCmp]) |=> !statusFlag);

endmodule

bind gtmr_top gtmr_checker #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .addr       (addr),
  .wrData     (wrData),
  .rdData     (rdData),
  .irq        (irq),
  .cntVal     (cntVal),
  .cmpVal     (cmpVal),
  .statusFlag (statusFlag),
  .ctrlBits   (ctrlBits)
);

// File: tb/tb_gtmr_top.sv
`timescale 1ns/1ps
module tb_gtmr_top;

  localparam int unsigned ADDR_W = 8;
  localparam int unsigned HALF_W = 32;

  localparam logic [7:0] A_CLO = 8'h00, A_CHI = 8'h04, A_CTL = 8'h08,
                         A_STS = 8'h0C, A_MLO = 8'h10, A_MHI = 8'h14;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [HALF_W-1:0] wrData = '0;
  logic [HALF_W-1:0] rdData;
  logic              irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    bit          chk;
    logic [31:0] exp;
    string       tag;
  } sbItem_t;

  sbItem_t sbQ[$];

  gtmr_top #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #2.5 clk = ~clk;

  // Monitor: pops one expected item per read cycle
  initial begin
    forever begin
      @(negedge clk);
      if (rdEn) begin
        if (sbQ.size() == 0) begin
          checks++; fails++;
          $display("FAIL scoreboard: read with no expected item");
        end else begin
          sbItem_t it;
          it = sbQ.pop_front();
          if (it.chk) begin
            checks++;
            if (rdData !== it.exp) begin
              fails++;
              $display("FAIL %s: got %h expected %h", it.tag, rdData, it.exp);
            end
          end
        end
      end
    end
  end

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0; addr = '0; wrData = '0;
  endtask

  task automatic busRd(input logic [7:0] a, input bit chk, input logic [31:0] exp,
                       input string tag, output logic [31:0] got);
    sbItem_t it;
    it.chk = chk; it.exp = exp; it.tag = tag;
    sbQ.push_back(it);
    rdEn = 1'b1; addr = a;
    @(negedge clk); got = rdData;
    @(posedge clk); #1;
    rdEn = 1'b0; addr = '0;
  endtask

  task automatic expectRd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] dummy;
    busRd(a, 1'b1, exp, tag, dummy);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic checkVal(input logic [63:0] got, input logic [63:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] hi, lo, saved;
    int retries;

    #12; rstN = 1'b1;
    @(posedge clk); #1;

    // R1: reset state
    expectRd(A_CLO, 32'h0, "R1 counter low");
    expectRd(A_CHI, 32'h0, "R1 counter high");
    expectRd(A_CTL, 32'h0, "R1 control");
    expectRd(A_STS, 32'h0, "R1 status");
    expectRd(A_MLO, 32'h0, "R1 compare low");
    expectRd(A_MHI, 32'h0, "R1 compare high");
    checkVal({63'd0, irq}, 64'd0, "R1 irq");

    // R3: control keeps only bits 2:0
    busWr(A_CTL, 32'hFFFF_FFFF);
    expectRd(A_CTL, 32'h0000_0007, "R3 control readback");
    busWr(A_CTL, 32'h0);
    busWr(A_STS, 32'h1);
    busWr(A_CLO, 32'h0);
    busWr(A_CHI, 32'h0);

    // R10: unmapped offsets
    busWr(8'h18, 32'hFFFF_FFFF);
    busWr(8'h03, 32'hFFFF_FFFF);
    expectRd(8'h18, 32'h0, "R10 unmapped read 0x18");
    expectRd(8'h03, 32'h0, "R10 unmapped read 0x03");
    expectRd(A_CTL, 32'h0, "R10 control untouched");
    expectRd(A_CLO, 32'h0, "R10 counter untouched");
    expectRd(A_MLO, 32'h0, "R10 compare untouched");
    expectRd(A_STS, 32'h0, "R10 status untouched");

    // R2: counting for ten edges, then hold
    busWr(A_CLO, 32'h10);
    busWr(A_CTL, 32'h1);
    idle(9);
    busWr(A_CTL, 32'h0);
    expectRd(A_CLO, 32'h1A, "R2 count after ten edges");
    idle(4);
    expectRd(A_CLO, 32'h1A, "R2 hold while stopped");

    // R4: word loads are independent
    busWr(A_CHI, 32'hABCD_0001);
    expectRd(A_CHI, 32'hABCD_0001, "R4 counter high load");
    expectRd(A_CLO, 32'h1A, "R4 counter low kept");
    busWr(A_MHI, 32'h1234_5678);
    busWr(A_MLO, 32'h9ABC_DEF0);
    expectRd(A_MHI, 32'h1234_5678, "R4 compare high load");
    expectRd(A_MLO, 32'h9ABC_DEF0, "R4 compare low load");

    // R5: torn read across rollover, then retry
    busWr(A_CLO, 32'hFFFF_FFFE);
    busWr(A_CHI, 32'h5);
    busWr(A_CTL, 32'h1);
    retries = 0;
    busRd(A_CHI, 1'b0, 32'h0, "", hi);
    do begin
      saved = hi;
      busRd(A_CLO, 1'b0, 32'h0, "", lo);
      busRd(A_CHI, 1'b0, 32'h0, "", hi);
      if (hi != saved) retries++;
    end while (hi != saved && retries < 8);
    busWr(A_CTL, 32'h0);
    checkVal(64'(retries), 64'd1, "R5 one retry across rollover");
    checkVal({hi, lo}, 64'h6_0000_0001, "R5 consistent 64-bit value");

    // Compare set-up: counter below compare
    busWr(A_CHI, 32'h0);
    busWr(A_CLO, 32'd100);
    busWr(A_MHI, 32'h0);
    busWr(A_MLO, 32'd200);
    busWr(A_CTL, 32'h6);
    expectRd(A_STS, 32'h0, "R6 no match below compare");

    // R6: equal value sets the flag, R9: interrupt follows
    busWr(A_CLO, 32'd200);
    idle(3);
    expectRd(A_STS, 32'h1, "R6 match at equal");
    checkVal({63'd0, irq}, 64'd1, "R9 irq raised");

    // R6: sticky after counter falls below
    busWr(A_CLO, 32'd0);
    idle(2);
    expectRd(A_STS, 32'h1, "R6 flag sticky");

    // R7: write 0 ignored, write 1 clears
    busWr(A_STS, 32'h0);
    expectRd(A_STS, 32'h1, "R7 zero write no effect");
    busWr(A_STS, 32'h1);
    expectRd(A_STS, 32'h0, "R7 clear");
    idle(2);
    checkVal({63'd0, irq}, 64'd0, "R7 irq dropped after clear");

    // R8: clear against live match
    busWr(A_CLO, 32'd300);
    idle(2);
    busWr(A_STS, 32'h1);
    expectRd(A_STS, 32'h1, "R8 set wins over clear");

    // R9: masking by interrupt enable and compare enable
    busWr(A_CTL, 32'h2);
    idle(2);
    checkVal({63'd0, irq}, 64'd0, "R9 irq masked by enable");
    busWr(A_CTL, 32'h6);
    idle(2);
    checkVal({63'd0, irq}, 64'd1, "R9 irq re-enabled");
    busWr(A_CTL, 32'h4);
    idle(2);
    checkVal({63'd0, irq}, 64'd0, "R9 irq off with compare disabled");
    expectRd(A_STS, 32'h1, "R9 flag still pending");

    // R11: compare disabled, counter above compare, no set
    busWr(A_STS, 32'h1);
    busWr(A_MLO, 32'd5);
    idle(3);
    expectRd(A_STS, 32'h0, "R11 no match while disabled");
    checkVal({63'd0, irq}, 64'd0, "R11 irq low");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule